// File: doc/BRIEF.md
# Serial Port Baud Tick Generator with Fast-Rate Option

This block produces the sixteen-times oversampling strobe that paces the transmitter and receiver of a 16550-class serial port. Software loads a 16-bit divisor as two bytes. The block divides a fixed base rate by that divisor and emits a strobe one system clock wide each time the division completes. The base rate is built inside the block from the system clock by a prescaler.

A separate fast-rate enable comes from device configuration, outside the serial port's own register set. While that enable is 1, a divisor with its most significant bit set selects a base rate four times higher, and the remaining 15 bits are the divisor. This reaches 230400 baud (low field 2) and 460800 baud (low field 1), which lie past the divisor-of-1 limit of 115200 baud. While the enable is 0, the top bit is an ordinary divisor bit. A divisor of zero stops the strobe. A newly loaded divisor takes effect when the current count runs out.

Top module: `uart_baud_gen`

## Requirements
- R1: While reset is asserted and directly after it, the strobe is low and both counters are cleared. With a nonzero divisor in normal mode, the first strobe is high in the cycle after the PRESCALE-th rising clock edge that follows reset release.
- R2: In normal mode the strobe repeats every D × PRESCALE system clock cycles, where D is the 16-bit divisor {high byte, low byte}.
- R3: Each strobe is high for exactly one system clock cycle.
- R4: With the fast-rate enable at 1 and divisor bit 15 at 1, the strobe repeats every L × PRESCALE/4 cycles, where L is divisor bits 14..0. L = 2 gives twice the divisor-1 rate and L = 1 gives four times that rate.
- R5: With the fast-rate enable at 0, divisor bit 15 counts as an ordinary divisor bit, so 0x8001 produces no strobe within the first 32769 × PRESCALE cycles of a period.
- R6: An effective divisor of zero stops the strobe. This covers 0x0000 in either mode, and 0x8000 while fast mode is active.
- R7: A divisor written during a count does not shorten or stretch the period in progress. The new value applies from the next terminal count.
- R8: Asserting reset in the middle of operation clears the strobe and counters at once. After release, timing restarts as described in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_lo_i | input | 8 | Divisor bits 7..0 |
| div_hi_i | input | 8 | Divisor bits 15..8 |
| fast_en_i | input | 1 | Fast-rate enable from device configuration |
| tick16_o | output | 1 | Sixteen-times baud strobe, one cycle wide |

## Verification
The in-line properties assume that the divisor bytes and the fast-rate enable are stable around the rising edge, because they are sampled straight into the count logic. They also assume that the fast base period is at least two system clocks, which is what makes the single-cycle strobe property valid. The bench changes every input on the falling edge only. It keeps the default prescale of 8, so the fastest legal setting still leaves one idle cycle between strobes. A behavioural model in the bench predicts the strobe on every cycle, including across divisor changes and mode switches made in the middle of a count.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

   localparam int unsigned DIV_W = 16;

   typedef logic [DIV_W-1:0] divisor_t;

   typedef struct packed {
      logic     fast;
      divisor_t count;
   } rate_sel_t;

   // Split the latched divisor into prescale choice and count value.
   function automatic rate_sel_t decode_rate(input divisor_t raw, input logic fast_allowed);
      rate_sel_t r;
      r.fast  = fast_allowed & raw[DIV_W-1];
      r.count = r.fast ? {1'b0, raw[DIV_W-2:0]} : raw;
      return r;
   endfunction

endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
   parameter int unsigned PRESCALE   = 8,
   parameter int unsigned FAST_RATIO = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fast_i,
   output logic base_en_o
);
   localparam int unsigned PW       = $clog2(PRESCALE + 1);
   localparam int unsigned FAST_DIV = PRESCALE / FAST_RATIO;
   localparam logic [PW-1:0] LIM_NORM = PW'(PRESCALE - 1);
   localparam logic [PW-1:0] LIM_FAST = PW'(FAST_DIV - 1);

   logic [PW-1:0] pre_q;
   logic [PW-1:0] lim;

   assign lim       = fast_i ? LIM_FAST : LIM_NORM;
   // ">=" lets a switch to the shorter period end the current one at once.
   assign base_en_o = (pre_q >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pre_q <= '0;
      else if (base_en_o) pre_q <= '0;
      else                pre_q <= pre_q + PW'(1);
   end

   a_r2_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= LIM_NORM);

endmodule

// File: rtl/baud_divider.sv
module baud_divider
   import uart_baud_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     base_en_i,
   input  divisor_t div_i,
   output logic     tick_o
);
   divisor_t cnt_q;
   logic     term;
   logic     live;

   assign term = (cnt_q <= divisor_t'(1));
   assign live = (div_i != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tick_o <= 1'b0;
      end else begin
         tick_o <= base_en_i & term & live;
         if (base_en_i) begin
            if (term) cnt_q <= div_i;
            else      cnt_q <= cnt_q - divisor_t'(1);
         end
      end
   end

   a_r7_tick_on_base: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |-> $past(base_en_i));

   a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !base_en_i |=> $stable(cnt_q));

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
   import uart_baud_pkg::*;
#(
   parameter int unsigned PRESCALE   = 8,
   parameter int unsigned FAST_RATIO = 4,
   parameter bit          FAST_SUPP  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] div_lo_i,
   input  logic [7:0] div_hi_i,
   input  logic       fast_en_i,
   output logic       tick16_o
);
   localparam int unsigned FAST_DIV = PRESCALE / FAST_RATIO;

   generate
      if (FAST_RATIO == 0 || (PRESCALE % FAST_RATIO) != 0) begin : g_bad_ratio
         $error("PRESCALE must be a multiple of FAST_RATIO");
      end
      if (FAST_DIV < 2) begin : g_bad_fast
         $error("fast base period must be at least two clocks");
      end
   endgenerate

   divisor_t  raw_div;
   logic      fast_allowed;
   rate_sel_t sel;
   logic      base_en;

   assign raw_div = {div_hi_i, div_lo_i};

   generate
      if (FAST_SUPP) begin : g_fast
         assign fast_allowed = fast_en_i;
      end else begin : g_plain
         assign fast_allowed = 1'b0;
      end
   endgenerate

   assign sel = decode_rate(raw_div, fast_allowed);

   baud_prescale #(
      .PRESCALE  (PRESCALE),
      .FAST_RATIO(FAST_RATIO)
   ) i_pre (
      .clk      (clk),
      .rst_n    (rst_n),
      .fast_i   (sel.fast),
      .base_en_o(base_en)
   );

   baud_divider i_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .base_en_i(base_en),
      .div_i   (sel.count),
      .tick_o  (tick16_o)
   );

   a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      tick16_o |=> !tick16_o);

   a_r6_zero_stops: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(raw_div) == '0) |-> !tick16_o);

endmodule

// File: tb/test_uart_baud_gen.sv
module test_uart_baud_gen;
   localparam int P = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] div_lo = 8'd0;
   logic [7:0] div_hi = 8'd0;
   logic       fast_en = 1'b0;
   logic       tick;

   int    errors = 0;
   int    checks = 0;
   string cur_req = "R1";
   bit    done = 1'b0;

   always #10 clk = ~clk;

   uart_baud_gen i_uart_baud_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .div_lo_i (div_lo),
      .div_hi_i (div_hi),
      .fast_en_i(fast_en),
      .tick16_o (tick)
   );

   // Behavioural reference: base-period phase and remaining base periods.
   int m_phase = 0;
   int m_left  = 0;
   bit m_tick  = 1'b0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_left = 0; m_tick = 1'b0;
      end else begin
         int  d;
         int  period;
         bit  hs;
         bit  fire;
         d      = {div_hi, div_lo};
         hs     = fast_en && div_hi[7];
         if (hs) d = d - 32768;
         period = hs ? P / 4 : P;
         fire   = (m_phase + 1 >= period);
         m_tick = fire && (m_left <= 1) && (d != 0);
         if (fire) begin
            m_phase = 0;
            m_left  = (m_left <= 1) ? d : m_left - 1;
         end else begin
            m_phase = m_phase + 1;
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   bit prev_tick = 1'b0;
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cur_req, tick, m_tick);
         if (prev_tick) chk("R3", tick, 0);
      end
      prev_tick = rst_n ? tick : 1'b0;
   end

   task automatic set_div(input int d, input bit hs);
      @(negedge clk);
      div_lo  = d[7:0];
      div_hi  = d[15:8];
      fast_en = hs;
   endtask

   task automatic wait_tick();
      do @(negedge clk); while (!tick);
   endtask

   task automatic gap(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!tick);
   endtask

   task automatic period_chk(input string req, input int exp);
      int n;
      wait_tick();
      gap(n);
      gap(n);
      chk(req, n, exp);
   endtask

   task automatic quiet_chk(input string req, input int cycles);
      int seen = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (tick) seen++;
      end
      chk(req, seen, 0);
   endtask

   task automatic summary();
      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
   end

   initial begin
      int n;
      // R1: reset state and first strobe position
      div_lo = 8'd12;
      repeat (3) @(negedge clk);
      chk("R1", tick, 0);
      rst_n = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!tick && n < 100);
      chk("R1", n, P);

      // R2: normal divisors 12, 1, 96
      cur_req = "R2";
      period_chk("R2", 12 * P);
      set_div(1, 1'b0);
      period_chk("R2", P);
      set_div(96, 1'b0);
      period_chk("R2", 96 * P);

      // R4: fast mode low field 2 and 1
      cur_req = "R4";
      set_div(16'h8002, 1'b1);
      period_chk("R4", 2 * P / 4);
      set_div(16'h8001, 1'b1);
      period_chk("R4", P / 4);

      // R5: enable off, bit 15 is part of the divisor
      cur_req = "R5";
      set_div(16'h8001, 1'b0);
      wait_tick();
      quiet_chk("R5", 3000);

      // R6: zero divisor in both modes
      cur_req = "R6";
      set_div(0, 1'b0);
      repeat (40 * P) @(negedge clk);
      quiet_chk("R6", 40 * P);
      set_div(16'h8000, 1'b1);
      quiet_chk("R6", 40 * P);
      set_div(0, 1'b1);
      quiet_chk("R6", 40 * P);

      // R7: divisor change mid-period applies from next terminal count
      cur_req = "R7";
      rst_n = 1'b0;
      set_div(20, 1'b0);
      rst_n = 1'b1;
      wait_tick();
      repeat (10) @(negedge clk);
      div_lo = 8'd5;
      gap(n);
      chk("R7", n, 20 * P - 10);
      gap(n);
      chk("R7", n, 5 * P);

      // R8: reset in the middle of a count
      cur_req = "R8";
      repeat (7) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R8", tick, 0);
      rst_n = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!tick && n < 100);
      chk("R8", n, P);
      period_chk("R8", 5 * P);

      summary();
   end
endmodule